// File: doc/BRIEF.md
# Strobed Parallel Input Port

This block is one 8-bit parallel input port working in strobed handshake mode. A peripheral drives a byte onto the port pins and pulses an active-low strobe. The port captures the byte into an input latch and raises a buffer-full flag. If interrupts are enabled, it also raises an interrupt request toward the CPU once the strobe returns high. The CPU then pulses its active-low read strobe. The falling edge of that read withdraws the interrupt request. The rising edge frees the buffer, and the peripheral may then send the next byte.

The peripheral strobe and the pin byte pass together through a synchronizer of `SYNC_STAGES` flops, so the byte stays aligned with its strobe. The CPU read strobe is treated as synchronous to `clk`. The interrupt enable is written through a dedicated write pulse and value input. All state clears on the synchronous active-high reset.

Top module: `strobed_input_port`

## Requirements
- R1: After reset, `ibf` is 0, `intr` is 0, `rd_data` is 0x00 and the interrupt enable is 0.
- R2: A strobe falling edge is the first clock edge that samples `stb_n` low after it was high. On the `SYNC_STAGES`-th rising clock edge after that edge, the byte present on `pin_data` together with the strobe is loaded into the latch, and `rd_data` shows it.
- R3: `ibf` becomes 1 on the same clock edge that loads the latch.
- R4: On the edge where the synchronized strobe is seen rising, `intr` is set to 1 if `ibf` and the interrupt enable were both 1 before that edge. With the enable at 0, `intr` stays 0.
- R5: The first clock edge that samples `rd_n` low after it was high clears `intr`. The first edge that samples `rd_n` high after it was low clears `ibf`.
- R6: A clock edge with `ie_wr`=1 loads `ie_din` into the interrupt enable. Writing 0 also clears `intr` on that edge.
- R7: A strobe that arrives while `ibf` is 1 overwrites the latch with the new byte, and `ibf` stays 1.
- R8: On one edge, a read falling edge beats an interrupt set, so `intr` stays 0. On one edge, a strobe capture beats a read rising edge, so `ibf` stays 1 and the new byte is held.
- R9: Without a strobe capture, `rd_data` keeps its value, including across reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_n | input | 1 | Peripheral strobe, active low |
| pin_data | input | 8 | Byte on the port pins |
| rd_n | input | 1 | CPU read strobe, active low |
| ie_wr | input | 1 | Write pulse for the interrupt enable |
| ie_din | input | 1 | Value written to the interrupt enable |
| rd_data | output | 8 | Latched byte returned to the CPU |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request, active high |

## Verification
The hardest cases to reach are the two same-edge collisions in R8. The strobe edge is seen only after the synchronizer, so a read edge must be placed exactly `SYNC_STAGES` clocks after the strobe pin changes. Directed sequences count negative edges from the strobe change to the read change and so land both events on one clock edge. A long pseudo-random phase then toggles every input against a cycle-by-cycle reference model, which also reaches overwrites and enable writes in the middle of a handshake.

// File: rtl/sip_pkg.sv
package sip_pkg;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_t;

    function automatic edge_t edge_of(input logic prev, input logic cur);
        edge_t e;
        e.fall = prev & ~cur;
        e.rise = ~prev & cur;
        return e;
    endfunction

    typedef struct packed {
        logic ibf;
        logic intr;
        logic ie;
    } flags_t;

endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
    parameter int W = 9,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] stage [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_st
                if (i == 0) begin : g_first
                    always_ff @(posedge clk) begin
                        if (rst) stage[i] <= RST_VAL;
                        else     stage[i] <= d;
                    end
                end else begin : g_next
                    always_ff @(posedge clk) begin
                        if (rst) stage[i] <= RST_VAL;
                        else     stage[i] <= stage[i-1];
                    end
                end
            end
            assign q = stage[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sip_edge.sv
module sip_edge
    import sip_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sig,
    output edge_t ev
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= sig;
    end

    assign ev = edge_of(prev, sig);
endmodule

// File: rtl/sip_core.sv
module sip_core
    import sip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  edge_t             stb_ev,
    input  edge_t             rd_ev,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ie_wr,
    input  logic              ie_din,
    output logic [DATA_W-1:0] latch,
    output flags_t            flags
);
    flags_t nxt;
    logic   clr_intr;
    logic   set_intr;

    always_comb begin
        nxt      = flags;
        clr_intr = rd_ev.fall | (ie_wr & ~ie_din);
        set_intr = stb_ev.rise & flags.ibf & flags.ie;
        if (clr_intr)      nxt.intr = 1'b0;
        else if (set_intr) nxt.intr = 1'b1;
        if (stb_ev.fall)     nxt.ibf = 1'b1;
        else if (rd_ev.rise) nxt.ibf = 1'b0;
        if (ie_wr) nxt.ie = ie_din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            latch <= '0;
        end else begin
            flags <= nxt;
            if (stb_ev.fall) latch <= data_in;
        end
    end
endmodule

// File: rtl/strobed_input_port.sv
module strobed_input_port
    import sip_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] pin_data,
    input  logic              rd_n,
    input  logic              ie_wr,
    input  logic              ie_din,
    output logic [DATA_W-1:0] rd_data,
    output logic              ibf,
    output logic              intr
);
    localparam int BUS_W = DATA_W + 1;
    localparam logic [BUS_W-1:0] BUS_RST = {1'b1, {DATA_W{1'b0}}};

    logic [BUS_W-1:0]  bus_sync;
    logic [DATA_W-1:0] data_s;
    logic              stb_s;
    edge_t             stb_ev;
    edge_t             rd_ev;
    flags_t            flags;
    logic              ie;

    sip_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
        .clk(clk), .rst(rst), .d({stb_n, pin_data}), .q(bus_sync)
    );

    assign stb_s  = bus_sync[DATA_W];
    assign data_s = bus_sync[DATA_W-1:0];

    sip_edge u_stb_edge (.clk(clk), .rst(rst), .sig(stb_s), .ev(stb_ev));
    sip_edge u_rd_edge  (.clk(clk), .rst(rst), .sig(rd_n),  .ev(rd_ev));

    sip_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst(rst), .stb_ev(stb_ev), .rd_ev(rd_ev),
        .data_in(data_s), .ie_wr(ie_wr), .ie_din(ie_din),
        .latch(rd_data), .flags(flags)
    );

    assign ibf  = flags.ibf;
    assign intr = flags.intr;
    assign ie   = flags.ie;
endmodule

// File: rtl/sip_checker.sv
module sip_checker
    import sip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input edge_t             stb_ev,
    input edge_t             rd_ev,
    input logic              ibf,
    input logic              intr,
    input logic              ie,
    input logic [DATA_W-1:0] rd_data
);
    AST_CAPTURE_SETS_IBF: assert property (@(posedge clk) disable iff (rst)
        stb_ev.fall |=> ibf); // R3

    AST_INTR_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        intr |-> ie); // R6

    AST_READ_FALL_DROPS_INTR: assert property (@(posedge clk) disable iff (rst)
        rd_ev.fall |=> !intr); // R5

    AST_INTR_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(intr) |-> $past(stb_ev.rise && ibf)); // R4

    AST_READ_RISE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (rd_ev.rise && !stb_ev.fall) |=> !ibf); // R5

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !stb_ev.fall |=> $stable(rd_data)); // R9
endmodule

bind strobed_input_port sip_checker #(.DATA_W(DATA_W)) u_sip_checker (
    .clk(clk), .rst(rst), .stb_ev(stb_ev), .rd_ev(rd_ev),
    .ibf(ibf), .intr(intr), .ie(ie), .rd_data(rd_data)
);

// File: tb/test_strobed_input_port.sv
module test_strobed_input_port;
    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb_n = 1'b1;
    logic [7:0] pin_data = 8'h00;
    logic       rd_n = 1'b1;
    logic       ie_wr = 1'b0;
    logic       ie_din = 1'b0;
    logic [7:0] rd_data;
    logic       ibf;
    logic       intr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    strobed_input_port #(.DATA_W(8), .SYNC_STAGES(STG)) i_strobed_input_port (
        .clk(clk), .rst(rst), .stb_n(stb_n), .pin_data(pin_data), .rd_n(rd_n),
        .ie_wr(ie_wr), .ie_din(ie_din), .rd_data(rd_data), .ibf(ibf), .intr(intr)
    );

    // behavioural reference model
    logic [8:0] m_pipe [$];
    logic [8:0] y;
    logic       m_sp, m_rp, m_ibf, m_intr, m_ie, n_intr, m_valid;
    logic       sf, sr, rf, rr;
    logic [7:0] m_latch;

    always @(posedge clk) begin
        if (rst) begin
            m_pipe = {};
            repeat (STG) m_pipe.push_back(9'h100);
            m_sp = 1; m_rp = 1; m_ibf = 0; m_intr = 0; m_ie = 0; m_latch = 0;
            m_valid = 1;
        end else begin
            y  = m_pipe[STG-1];
            sf = m_sp & ~y[8];
            sr = ~m_sp & y[8];
            rf = m_rp & ~rd_n;
            rr = ~m_rp & rd_n;
            n_intr = m_intr;
            if (rf || (ie_wr && !ie_din)) n_intr = 0;
            else if (sr && m_ibf && m_ie) n_intr = 1;
            if (sf) begin m_ibf = 1; m_latch = y[7:0]; end
            else if (rr) m_ibf = 0;
            m_intr = n_intr;
            if (ie_wr) m_ie = ie_din;
            m_sp = y[8];
            m_rp = rd_n;
            void'(m_pipe.pop_back());
            m_pipe.push_front({stb_n, pin_data});
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid === 1'b1 && !done) begin
            chk("R2 rd_data vs model", rd_data, m_latch);
            chk("R3 ibf vs model", ibf, m_ibf);
            chk("R4 intr vs model", intr, m_intr);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] b);
        @(negedge clk); pin_data = b; stb_n = 0;
        cyc(3); stb_n = 1;
        cyc(4);
    endtask

    task automatic read_cycle();
        @(negedge clk); rd_n = 0;
        cyc(2); rd_n = 1;
        cyc(2);
    endtask

    task automatic set_ie(input logic v);
        @(negedge clk); ie_wr = 1; ie_din = v;
        @(negedge clk); ie_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int lfsr;
        cyc(3);
        rst = 0;
        cyc(1);
        #1;
        chk("R1 ibf after reset", ibf, 0);
        chk("R1 intr after reset", intr, 0);
        chk("R1 rd_data after reset", rd_data, 0);

        strobe(8'hA5);
        chk("R2 byte captured", rd_data, 8'hA5);
        chk("R3 ibf set", ibf, 1);
        chk("R4 no intr with enable clear (R1 enable reset)", intr, 0);

        read_cycle();
        chk("R5 ibf cleared by read", ibf, 0);
        chk("R9 latch kept across read", rd_data, 8'hA5);

        set_ie(1);
        strobe(8'h3C);
        chk("R4 intr raised", intr, 1);
        @(negedge clk); rd_n = 0;
        @(negedge clk);
        chk("R5 intr cleared on read fall", intr, 0);
        chk("R5 ibf held during read", ibf, 1);
        rd_n = 1;
        @(negedge clk);
        chk("R5 ibf cleared on read rise", ibf, 0);

        strobe(8'h11);
        strobe(8'h22);
        chk("R7 overwrite latch", rd_data, 8'h22);
        chk("R7 ibf still set", ibf, 1);
        set_ie(0);
        chk("R6 disable clears intr", intr, 0);
        set_ie(1);
        read_cycle();

        // R8: read fall lands on the edge that sees the strobe rise
        @(negedge clk); pin_data = 8'h5A; stb_n = 0;
        cyc(4);
        chk("R8 setup ibf", ibf, 1);
        stb_n = 1;
        cyc(STG); rd_n = 0;
        @(negedge clk);
        chk("R8 read fall beats intr set", intr, 0);
        rd_n = 1;
        cyc(2);

        // R8: strobe capture lands on the edge that sees the read rise
        @(negedge clk); rd_n = 0;
        @(negedge clk); pin_data = 8'hC3; stb_n = 0;
        cyc(STG); rd_n = 1;
        @(negedge clk);
        chk("R8 capture beats read rise ibf", ibf, 1);
        chk("R8 capture beats read rise data", rd_data, 8'hC3);
        stb_n = 1;
        cyc(4);
        read_cycle();

        // pseudo-random phase checked against the model
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            if (lfsr[3:1] == 0) stb_n = ~stb_n;
            if (lfsr[7:5] == 0) rd_n = ~rd_n;
            ie_wr    = (lfsr[12:9] == 0);
            ie_din   = lfsr[13];
            pin_data = lfsr[23:16];
        end
        @(negedge clk); ie_wr = 0;
        cyc(4);
        finish_run();
    end
endmodule